// File: doc/BRIEF.md
# Load/Store Byte Lane Aligner

This unit sits between a processor pipeline and a data memory that is 32 bits wide and addressed by word. Each request carries a base register value, a 16-bit offset, an access size, a signedness flag and a direction. The unit adds the sign-extended offset to the base to form a byte address. It presents the word address to memory. For a store it also presents a 4-bit lane write-enable and store data with its low bits copied into every lane. For a load it takes the word that the memory returns, picks out the addressed byte or halfword and widens it with sign or zero bits.

Byte lanes are little-endian: lane n holds data bits 8n+7..8n and is selected by byte address bits 1:0 equal to n. A halfword access whose address is odd, or a word access whose address is not a multiple of four, is only flagged. It makes no memory access and writes nothing. All outputs are registered. Memory-side outputs appear one cycle after the request. The memory answers in the next cycle, as a synchronous block RAM does. The load result appears two cycles after the request.

Top module: `ldst_lane_aligner`

## Requirements
- R1: One cycle after a valid aligned request, `mem_en` is 1 and `mem_addr` equals bits 31:2 of (`req_base` + sign-extended `req_offset`), wrapping modulo 2^32.
- R2: A byte store (`req_size` 00) sets exactly one bit of `mem_be`, bit n where n is address bits 1:0, and drives `mem_wdata` with four copies of bits 7:0 of the store data.
- R3: A halfword store (`req_size` 01) with address bit 0 clear drives `mem_be` 0011 when address bit 1 is 0 and 1100 when it is 1. `mem_wdata` is two copies of bits 15:0 of the store data.
- R4: A word store (`req_size` 10, with 11 treated the same) at a multiple of four drives `mem_be` 1111 and `mem_wdata` equal to the store data.
- R5: A halfword request with address bit 0 set, or a word request with address bits 1:0 non-zero, raises `mem_misalign` one cycle later with `mem_en` 0, `mem_we` 0 and `mem_be` 0000. A misaligned load never raises `ld_valid`. Byte requests are never misaligned.
- R6: A signed byte load (`req_unsigned` 0) returns the selected lane's byte sign-extended to 32 bits on `ld_data`, with `ld_valid` 1, two cycles after the request. `mem_rdata` is sampled one cycle after the request.
- R7: An unsigned byte load (`req_unsigned` 1) returns the selected byte with the upper 24 bits zero.
- R8: A halfword load returns lanes {2k+1, 2k}, where k is address bit 1. The result is sign-extended when `req_unsigned` is 0 and zero-extended when it is 1.
- R9: A word load returns `mem_rdata` unchanged, whatever `req_unsigned` is.
- R10: While `rst` is high, and in the cycle after it, every output is zero.
- R11: A cycle with `req_valid` 0 gives `mem_en`, `mem_we`, `mem_be` and `mem_misalign` all 0 in the next cycle and `ld_valid` 0 two cycles later. Loads never drive `mem_we` or `mem_be`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Load extension: 1 zero, 0 sign |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data register value |
| mem_rdata | input | 32 | Word returned by memory, one cycle after request |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Lane write-enables |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_misalign | output | 1 | Request was misaligned |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Extended load result |

## Verification
Byte and halfword stores are driven at every legal lane position with the same distinctive store word. Because every lane of that word differs, a lane-enable that is off by one position or copies the wrong bits shows up at once. Loads read a word whose lanes alternate between set and clear top bits, so each lane read both signed and unsigned tells sign extension apart from zero extension and exposes the wrong lane. Misaligned halfword and word addresses, negative offsets that borrow into the upper address bits, and idle cycles with data still on the inputs separate the flagging, the address adder and the gating by the valid input.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE     = 2'b00,
    SZ_HALF     = 2'b01,
    SZ_WORD     = 2'b10,
    SZ_WORD_ALT = 2'b11
  } acc_size_e;

  localparam int unsigned LANE_BITS = 8;
endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] eff_o
);
  localparam int unsigned EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;

  always_comb begin
    off_ext = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
    eff_o   = base_i + off_ext;
  end
endmodule

// File: rtl/lsa_store_steer.sv
module lsa_store_steer
  import lsa_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  acc_size_e                          size_i,
  input  logic [$clog2(DATA_W/LANE_BITS)-1:0] lo_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  output logic [DATA_W/LANE_BITS-1:0]        be_o,
  output logic [DATA_W-1:0]                  wdata_o,
  output logic                               misalign_o
);
  localparam int unsigned LANES = DATA_W / LANE_BITS;
  localparam int unsigned IDX_W = $clog2(LANES);

  logic [DATA_W-1:0] rep_byte;
  logic [DATA_W-1:0] rep_half;
  logic [LANES-1:0]  be_raw;
  logic [IDX_W-1:0]  pair_base;

  for (genvar g = 0; g < LANES; g++) begin : g_rep
    assign rep_byte[g*LANE_BITS +: LANE_BITS] = wdata_i[LANE_BITS-1:0];
    assign rep_half[g*LANE_BITS +: LANE_BITS] = wdata_i[(g % 2)*LANE_BITS +: LANE_BITS];
  end

  assign pair_base = {lo_i[IDX_W-1:1], 1'b0};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        be_raw     = LANES'(1) << lo_i;
        wdata_o    = rep_byte;
        misalign_o = 1'b0;
      end
      SZ_HALF: begin
        be_raw     = LANES'(3) << pair_base;
        wdata_o    = rep_half;
        misalign_o = lo_i[0];
      end
      default: begin
        be_raw     = '1;
        wdata_o    = wdata_i;
        misalign_o = |lo_i;
      end
    endcase
    be_o = misalign_o ? '0 : be_raw;
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  acc_size_e                          size_i,
  input  logic                               unsigned_i,
  input  logic [$clog2(DATA_W/LANE_BITS)-1:0] lo_i,
  input  logic [DATA_W-1:0]                  word_i,
  output logic [DATA_W-1:0]                  data_o
);
  localparam int unsigned LANES  = DATA_W / LANE_BITS;
  localparam int unsigned IDX_W  = $clog2(LANES);
  localparam int unsigned HALF_W = 2 * LANE_BITS;

  logic [LANE_BITS-1:0] lane [LANES];
  logic [LANE_BITS-1:0] sel_byte;
  logic [HALF_W-1:0]    sel_half;
  logic [IDX_W-1:0]     idx_lo;
  logic [IDX_W-1:0]     idx_hi;
  logic                 fill_b;
  logic                 fill_h;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_i[g*LANE_BITS +: LANE_BITS];
  end

  always_comb begin
    idx_lo   = {lo_i[IDX_W-1:1], 1'b0};
    idx_hi   = {lo_i[IDX_W-1:1], 1'b1};
    sel_byte = lane[lo_i];
    sel_half = {lane[idx_hi], lane[idx_lo]};
    fill_b   = ~unsigned_i & sel_byte[LANE_BITS-1];
    fill_h   = ~unsigned_i & sel_half[HALF_W-1];
    unique case (size_i)
      SZ_BYTE: data_o = {{(DATA_W-LANE_BITS){fill_b}}, sel_byte};
      SZ_HALF: data_o = {{(DATA_W-HALF_W){fill_h}}, sel_half};
      default: data_o = word_i;
    endcase
  end
endmodule

// File: rtl/ldst_lane_aligner.sv
module ldst_lane_aligner
  import lsa_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16,
  localparam int unsigned LANES = DATA_W / LANE_BITS,
  localparam int unsigned IDX_W = $clog2(LANES),
  localparam int unsigned WA_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [WA_W-1:0]   mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_misalign,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  acc_size_e         size_in;
  logic [ADDR_W-1:0] eff;
  logic [LANES-1:0]  be_c;
  logic [DATA_W-1:0] wdata_c;
  logic              mis_c;
  logic [DATA_W-1:0] ext_c;

  logic              ld_pend_q;
  logic [IDX_W-1:0]  lo_q;
  acc_size_e         size_q;
  logic              uns_q;

  assign size_in = acc_size_e'(req_size);

  lsa_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .base_i   (req_base),
    .offset_i (req_offset),
    .eff_o    (eff)
  );

  lsa_store_steer #(.DATA_W(DATA_W)) u_steer (
    .size_i     (size_in),
    .lo_i       (eff[IDX_W-1:0]),
    .wdata_i    (req_wdata),
    .be_o       (be_c),
    .wdata_o    (wdata_c),
    .misalign_o (mis_c)
  );

  lsa_load_extract #(.DATA_W(DATA_W)) u_extract (
    .size_i     (size_q),
    .unsigned_i (uns_q),
    .lo_i       (lo_q),
    .word_i     (mem_rdata),
    .data_o     (ext_c)
  );

  // Request stage: memory-side outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en       <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_be       <= '0;
      mem_wdata    <= '0;
      mem_misalign <= 1'b0;
      ld_pend_q    <= 1'b0;
      lo_q         <= '0;
      size_q       <= SZ_BYTE;
      uns_q        <= 1'b0;
    end else begin
      mem_en       <= req_valid & ~mis_c;
      mem_we       <= req_valid & req_store & ~mis_c;
      mem_be       <= (req_valid & req_store) ? be_c : '0;
      mem_wdata    <= (req_valid & req_store & ~mis_c) ? wdata_c : '0;
      mem_misalign <= req_valid & mis_c;
      ld_pend_q    <= req_valid & ~req_store & ~mis_c;
      if (req_valid) begin
        mem_addr <= eff[ADDR_W-1:IDX_W];
        lo_q     <= eff[IDX_W-1:0];
        size_q   <= size_in;
        uns_q    <= req_unsigned;
      end
    end
  end

  // Response stage: extended load result
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= ld_pend_q;
      if (ld_pend_q) ld_data <= ext_c;
    end
  end

  AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (rst)
    mem_misalign |-> (mem_be == '0 && !mem_en && !mem_we)); // R5
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    (mem_we && size_q == SZ_BYTE) |-> $onehot(mem_be)); // R2
  AST_HALF_PAIR: assert property (@(posedge clk) disable iff (rst)
    (mem_we && size_q == SZ_HALF) |-> ($countones(mem_be) == 2 && !lo_q[0])); // R3
  AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
    (mem_we && size_q[1]) |-> (mem_be == '1)); // R4
  AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(mem_en && !mem_we)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> (!mem_en && !mem_misalign && mem_be == '0)); // R11
  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |-> (mem_be == '0)); // R11
endmodule

// File: tb/ldst_lane_aligner_bench.sv
module ldst_lane_aligner_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_store, req_unsigned;
  logic [1:0]  req_size;
  logic [31:0] req_base, req_wdata, mem_rdata;
  logic [15:0] req_offset;
  logic        mem_en, mem_we, mem_misalign, ld_valid;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, ld_data;

  int checks = 0;
  int errors = 0;

  logic        s_en, s_we, s_mis, s_ldv;
  logic [29:0] s_addr;
  logic [3:0]  s_be;
  logic [31:0] s_wd, s_ld;

  always #10 clk = ~clk;

  ldst_lane_aligner u_ldst_lane_aligner (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_offset(req_offset), .req_wdata(req_wdata), .mem_rdata(mem_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_misalign(mem_misalign), .ld_valid(ld_valid),
    .ld_data(ld_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One request; samples stage-1 outputs, then presents rdata and samples load result
  task automatic issue(input logic st, input logic [1:0] sz, input logic uns,
                       input logic [31:0] base, input logic [15:0] off,
                       input logic [31:0] wd, input logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
    req_base = base; req_offset = off; req_wdata = wd;
    @(negedge clk);
    s_en = mem_en; s_we = mem_we; s_mis = mem_misalign;
    s_addr = mem_addr; s_be = mem_be; s_wd = mem_wdata;
    req_valid = 1'b0; mem_rdata = rd;
    @(negedge clk);
    s_ldv = ld_valid; s_ld = ld_data;
    mem_rdata = '0;
  endtask

  task automatic t_reset;
    chk("R10 mem_en", {31'd0, mem_en}, 32'd0);
    chk("R10 mem_be", {28'd0, mem_be}, 32'd0);
    chk("R10 mem_addr", {2'd0, mem_addr}, 32'd0);
    chk("R10 misalign", {31'd0, mem_misalign}, 32'd0);
    chk("R10 ld_valid", {31'd0, ld_valid}, 32'd0);
    chk("R10 ld_data", ld_data, 32'd0);
  endtask

  task automatic t_addr;
    issue(1'b0, 2'b10, 1'b0, 32'h0000_1000, 16'hFFFC, 32'h0, 32'h1234_5678);
    chk("R1 en", {31'd0, s_en}, 32'd1);
    chk("R1 addr neg offset", {2'd0, s_addr}, 32'h0000_03FF);
    issue(1'b0, 2'b10, 1'b0, 32'h7FFF_FFF0, 16'h0010, 32'h0, 32'h0);
    chk("R1 addr carry", {2'd0, s_addr}, 32'h2000_0000);
    issue(1'b0, 2'b00, 1'b0, 32'h0000_0002, 16'h8000, 32'h0, 32'h0);
    chk("R1 addr wrap", {2'd0, s_addr}, 32'h3FFF_E000);
  endtask

  task automatic t_store_byte;
    for (int n = 0; n < 4; n++) begin
      issue(1'b1, 2'b00, 1'b0, 32'h0000_0100, 16'(n), 32'hA1B2_C3D4, 32'h0);
      chk("R2 be", {28'd0, s_be}, 32'(4'b0001 << n));
      chk("R2 wdata", s_wd, 32'hD4D4_D4D4);
      chk("R2 we", {31'd0, s_we}, 32'd1);
    end
  endtask

  task automatic t_store_half;
    issue(1'b1, 2'b01, 1'b0, 32'h0000_0200, 16'd0, 32'hA1B2_C3D4, 32'h0);
    chk("R3 be low", {28'd0, s_be}, 32'h3);
    chk("R3 wdata", s_wd, 32'hC3D4_C3D4);
    issue(1'b1, 2'b01, 1'b0, 32'h0000_0200, 16'd2, 32'hA1B2_C3D4, 32'h0);
    chk("R3 be high", {28'd0, s_be}, 32'hC);
    chk("R3 wdata high", s_wd, 32'hC3D4_C3D4);
  endtask

  task automatic t_store_word;
    issue(1'b1, 2'b10, 1'b0, 32'h0000_0300, 16'd4, 32'hA1B2_C3D4, 32'h0);
    chk("R4 be", {28'd0, s_be}, 32'hF);
    chk("R4 wdata", s_wd, 32'hA1B2_C3D4);
    issue(1'b1, 2'b11, 1'b0, 32'h0000_0300, 16'd8, 32'h0102_0304, 32'h0);
    chk("R4 size 11 be", {28'd0, s_be}, 32'hF);
  endtask

  task automatic t_misalign;
    for (int n = 1; n < 4; n += 2) begin
      issue(1'b1, 2'b01, 1'b0, 32'h0000_0400, 16'(n), 32'hFFFF_FFFF, 32'h0);
      chk("R5 half flag", {31'd0, s_mis}, 32'd1);
      chk("R5 half be", {28'd0, s_be}, 32'd0);
      chk("R5 half en", {30'd0, s_en, s_we}, 32'd0);
    end
    for (int n = 1; n < 4; n++) begin
      issue(1'b1, 2'b10, 1'b0, 32'h0000_0400, 16'(n), 32'hFFFF_FFFF, 32'h0);
      chk("R5 word flag", {31'd0, s_mis}, 32'd1);
      chk("R5 word be", {28'd0, s_be}, 32'd0);
    end
    issue(1'b0, 2'b10, 1'b0, 32'h0000_0401, 16'd0, 32'h0, 32'hDEAD_BEEF);
    chk("R5 load flag", {31'd0, s_mis}, 32'd1);
    chk("R5 load no result", {31'd0, s_ldv}, 32'd0);
    issue(1'b1, 2'b00, 1'b0, 32'h0000_0403, 16'd0, 32'h55, 32'h0);
    chk("R5 byte never misaligned", {31'd0, s_mis}, 32'd0);
  endtask

  task automatic t_load_byte;
    logic [31:0] w = 32'h807F_F001;
    logic [31:0] sx [4] = '{32'h0000_0001, 32'hFFFF_FFF0, 32'h0000_007F, 32'hFFFF_FF80};
    logic [31:0] zx [4] = '{32'h0000_0001, 32'h0000_00F0, 32'h0000_007F, 32'h0000_0080};
    for (int n = 0; n < 4; n++) begin
      issue(1'b0, 2'b00, 1'b0, 32'h0000_0500, 16'(n), 32'h0, w);
      chk("R6 valid", {31'd0, s_ldv}, 32'd1);
      chk("R6 signed byte", s_ld, sx[n]);
      chk("R11 load be", {28'd0, s_be}, 32'd0);
      issue(1'b0, 2'b00, 1'b1, 32'h0000_0500, 16'(n), 32'h0, w);
      chk("R7 unsigned byte", s_ld, zx[n]);
    end
  endtask

  task automatic t_load_half;
    logic [31:0] w = 32'h8001_7FFE;
    issue(1'b0, 2'b01, 1'b0, 32'h0000_0600, 16'd0, 32'h0, w);
    chk("R8 signed low", s_ld, 32'h0000_7FFE);
    issue(1'b0, 2'b01, 1'b1, 32'h0000_0600, 16'd0, 32'h0, w);
    chk("R8 unsigned low", s_ld, 32'h0000_7FFE);
    issue(1'b0, 2'b01, 1'b0, 32'h0000_0600, 16'd2, 32'h0, w);
    chk("R8 signed high", s_ld, 32'hFFFF_8001);
    issue(1'b0, 2'b01, 1'b1, 32'h0000_0600, 16'd2, 32'h0, w);
    chk("R8 unsigned high", s_ld, 32'h0000_8001);
  endtask

  task automatic t_load_word;
    issue(1'b0, 2'b10, 1'b0, 32'h0000_0700, 16'd0, 32'h0, 32'hF00D_8421);
    chk("R9 word signed", s_ld, 32'hF00D_8421);
    issue(1'b0, 2'b10, 1'b1, 32'h0000_0700, 16'd0, 32'h0, 32'h8000_0080);
    chk("R9 word unsigned", s_ld, 32'h8000_0080);
  endtask

  task automatic t_idle;
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b1; req_size = 2'b10;
    req_base = 32'h0000_0800; req_offset = 16'd0; req_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R11 idle en", {30'd0, mem_en, mem_we}, 32'd0);
    chk("R11 idle be", {28'd0, mem_be}, 32'd0);
    chk("R11 idle misalign", {31'd0, mem_misalign}, 32'd0);
    @(negedge clk);
    chk("R11 idle ld_valid", {31'd0, ld_valid}, 32'd0);
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_store = 1'b0; req_size = 2'b00;
    req_unsigned = 1'b0; req_base = '0; req_offset = '0; req_wdata = '0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_addr();
    t_store_byte();
    t_store_half();
    t_store_word();
    t_misalign();
    t_load_byte();
    t_load_half();
    t_load_word();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule